// File: doc/BRIEF.md
# Addressable Output Latch with Demultiplexer Mode

This block keeps a small vector of output bits that software-free logic updates one bit at a time from a single serial data line. A binary address picks the bit, and two active-low controls (a write enable and a clear) choose what happens to the vector at each rising edge of the system clock.

The two controls select one of four modes. In the write mode only the addressed bit takes the data value. The hold mode freezes the whole vector. The demultiplexer mode routes the data bit to the addressed output and drives every other output to zero. The clear mode forces all outputs to zero.

Storage and outputs are the same register. The result of any mode therefore stays visible after a later switch into the hold mode. Both the address width and the presence of a synchronous system reset are parameters. The output count is derived from the address width (eight outputs by default).

Top module: `addressable_latch`

## Requirements
- R1: With `wr_en_n_i`=0 and `clr_n_i`=1 (write mode), the output bit chosen by the address takes the value of `data_i` at the rising edge, and all other output bits keep their values.
- R2: Address value k (unsigned binary, `addr_i[ADDR_W-1]` most significant) selects output bit `q_o[k]`, and outputs are non-inverting: a 1 on `data_i` appears as 1.
- R3: With `wr_en_n_i`=1 and `clr_n_i`=1 (hold mode), the output vector is unchanged, whatever `data_i` and `addr_i` do.
- R4: With `wr_en_n_i`=0 and `clr_n_i`=0 (demultiplexer mode), after the edge `q_o[addr]` equals `data_i` and every other bit is 0.
- R5: With `wr_en_n_i`=1 and `clr_n_i`=0 (clear mode), after the edge all output bits are 0, regardless of address and data.
- R6: Switching from the clear or demultiplexer mode into the hold mode keeps the vector that mode produced.
- R7: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge; a change of inputs between edges does not move the outputs.
- R8: When `HAS_SRST`=1, `srst_i`=1 at a rising edge clears the vector to all zeros, and this takes precedence over every mode.
- R9: Address and data transitions that settle before the rising edge have no effect: only the values present at the edge decide which bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge active |
| srst_i | input | 1 | Synchronous system reset, active high |
| data_i | input | 1 | Serial data bit |
| addr_i | input | ADDR_W (3) | Output bit select |
| wr_en_n_i | input | 1 | Active-low write enable |
| clr_n_i | input | 1 | Active-low clear |
| q_o | output | 2**ADDR_W (8) | Registered output vector |

## Verification
Two functions can meet in the same cycle. The system reset can arrive while the mode inputs request a write or a demultiplexer pass of a 1, and a demultiplexer or clear result is immediately followed by the hold mode. The bench provokes the first by raising `srst_i` with write mode, address 5 and data 1, and expects all zeros. It provokes the second with directed clear-to-hold and demultiplexer-to-hold sequences and with random mode sequences. In every case the result is judged against a bench model that evaluates the mode table bit by bit.

// File: rtl/addressable_latch_pkg.sv
package addressable_latch_pkg;

   // Operating mode derived from the two active-low controls
   typedef enum logic [1:0] {
      MODE_WRITE = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_DEMUX = 2'd2,
      MODE_CLEAR = 2'd3
   } lat_mode_t;

endpackage

// File: rtl/addressable_latch_mode_dec.sv
module addressable_latch_mode_dec
   import addressable_latch_pkg::*;
(
   input  logic      wr_en_n_i,
   input  logic      clr_n_i,
   output lat_mode_t mode_o
);

   always_comb begin
      unique case ({clr_n_i, wr_en_n_i})
         2'b10:   mode_o = MODE_WRITE;
         2'b11:   mode_o = MODE_HOLD;
         2'b00:   mode_o = MODE_DEMUX;
         default: mode_o = MODE_CLEAR;
      endcase
   end

endmodule

// File: rtl/addressable_latch_onehot.sv
module addressable_latch_onehot #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned N_OUT = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [N_OUT-1:0]  sel_o
);

   for (genvar k = 0; k < N_OUT; k++) begin : g_sel
      assign sel_o[k] = (addr_i == ADDR_W'(k));
   end

endmodule

// File: rtl/addressable_latch_cell.sv
module addressable_latch_cell
   import addressable_latch_pkg::*;
(
   input  logic      clk_i,
   input  logic      srst_i,
   input  logic      sel_i,
   input  logic      data_i,
   input  lat_mode_t mode_i,
   output logic      q_o
);

   logic nxt;

   always_comb begin
      unique case (mode_i)
         MODE_WRITE: nxt = sel_i ? data_i : q_o;
         MODE_HOLD:  nxt = q_o;
         MODE_DEMUX: nxt = sel_i & data_i;
         default:    nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (srst_i) q_o <= 1'b0;
      else        q_o <= nxt;
   end

endmodule

// File: rtl/addressable_latch.sv
module addressable_latch
   import addressable_latch_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter bit          HAS_SRST = 1'b1,
   localparam int unsigned N_OUT   = 1 << ADDR_W
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              data_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_n_i,
   input  logic              clr_n_i,
   output logic [N_OUT-1:0]  q_o
);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr_w
      $error("addressable_latch: ADDR_W must lie in 1..6");
   end

   logic       srst_eff;
   lat_mode_t  mode;
   logic [N_OUT-1:0] sel_vec;

   if (HAS_SRST) begin : g_srst
      assign srst_eff = srst_i;
   end else begin : g_no_srst
      assign srst_eff = 1'b0;
   end

   addressable_latch_mode_dec u_mode (
      .wr_en_n_i (wr_en_n_i),
      .clr_n_i   (clr_n_i),
      .mode_o    (mode)
   );

   addressable_latch_onehot #(.ADDR_W(ADDR_W)) u_sel (
      .addr_i (addr_i),
      .sel_o  (sel_vec)
   );

   for (genvar k = 0; k < N_OUT; k++) begin : g_cell
      addressable_latch_cell u_cell (
         .clk_i  (clk_i),
         .srst_i (srst_eff),
         .sel_i  (sel_vec[k]),
         .data_i (data_i),
         .mode_i (mode),
         .q_o    (q_o[k])
      );
   end

   // R1
   write_bit_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (!wr_en_n_i && clr_n_i) |=> (q_o[$past(addr_i)] == $past(data_i)));

   // R1
   write_others_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (!wr_en_n_i && clr_n_i) |=>
         (((q_o ^ $past(q_o)) & ~(N_OUT'(1) << $past(addr_i))) == '0));

   // R3
   hold_stable_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (wr_en_n_i && clr_n_i) |=> $stable(q_o));

   // R4
   demux_onehot_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (!wr_en_n_i && !clr_n_i) |=>
         ($onehot0(q_o) && ($countones(q_o) == int'($past(data_i)))));

   // R4
   demux_route_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (!wr_en_n_i && !clr_n_i) |=> (q_o[$past(addr_i)] == $past(data_i)));

   // R5
   clear_zero_chk: assert property (@(posedge clk_i) disable iff (srst_eff)
      (wr_en_n_i && !clr_n_i) |=> (q_o == '0));

   // R8
   srst_zero_chk: assert property (@(posedge clk_i)
      srst_eff |=> (q_o == '0));

endmodule

// File: tb/addressable_latch_tb_top.sv
module addressable_latch_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 3;
   localparam int NO = 1 << AW;

   logic          clk;
   logic          srst;
   logic          data;
   logic [AW-1:0] addr;
   logic          wr_en_n;
   logic          clr_n;
   logic [NO-1:0] q;

   logic [NO-1:0] exp_q;
   int            n_cmp;
   int            n_bad;
   bit            done;

   addressable_latch #(.ADDR_W(AW), .HAS_SRST(1'b1)) dut_i (
      .clk_i     (clk),
      .srst_i    (srst),
      .data_i    (data),
      .addr_i    (addr),
      .wr_en_n_i (wr_en_n),
      .clr_n_i   (clr_n),
      .q_o       (q)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // model of the mode table, evaluated bit by bit
   function automatic logic [NO-1:0] model_next(input logic [NO-1:0] cur,
                                                input logic en_n, input logic cl_n,
                                                input logic [AW-1:0] a, input logic d);
      logic [NO-1:0] r;
      for (int k = 0; k < NO; k++) begin
         if (!cl_n)      r[k] = (!en_n && (k == int'(a))) ? d : 1'b0;
         else if (en_n)  r[k] = cur[k];
         else            r[k] = (k == int'(a)) ? d : cur[k];
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
      end
   endtask

   // inputs are applied at a falling edge; checked at the following falling edge
   task automatic step(input string tag, input logic en_n, input logic cl_n,
                       input logic [AW-1:0] a, input logic d, input bit glitch);
      wr_en_n = en_n; clr_n = cl_n; addr = a; data = d;
      #(CLK_PERIOD/4);
      check("R7 between edges", q, exp_q);
      if (glitch) begin
         addr = ~a; data = ~d;
         #(CLK_PERIOD/8);
         addr = a; data = d;
      end
      @(posedge clk);
      if (srst) exp_q = '0;
      else      exp_q = model_next(exp_q, en_n, cl_n, a, d);
      @(negedge clk);
      check(tag, q, exp_q);
   endtask

   initial begin
      n_cmp = 0; n_bad = 0; done = 1'b0;
      srst = 1'b1; data = 1'b1; addr = '1; wr_en_n = 1'b0; clr_n = 1'b1;
      exp_q = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset state", q, '0);
      srst = 1'b0;

      // R1 R2: walk a one across every address
      for (int k = 0; k < NO; k++) begin
         step("R1 write", 1'b0, 1'b1, AW'(k), 1'b1, 1'b0);
         n_cmp++;
         if (q[k] !== 1'b1) begin
            n_bad++;
            $display("FAIL R2 bit %0d: actual %b expected 1", k, q[k]);
         end
      end
      // R1: clear alternate bits by write
      for (int k = 0; k < NO; k += 2) step("R1 write zero", 1'b0, 1'b1, AW'(k), 1'b0, 1'b0);

      // R3: hold with moving data and address
      for (int k = 0; k < NO; k++) step("R3 hold", 1'b1, 1'b1, AW'(k), k[0], 1'b0);

      // R9: glitches before the edge in write mode
      step("R9 glitch write", 1'b0, 1'b1, 3'd3, 1'b1, 1'b1);
      step("R9 glitch write", 1'b0, 1'b1, 3'd6, 1'b0, 1'b1);

      // R5 then R6
      step("R5 clear", 1'b1, 1'b0, 3'd2, 1'b1, 1'b0);
      step("R6 clear to hold", 1'b1, 1'b1, 3'd7, 1'b1, 1'b0);

      // R4: demux every address with both data values
      for (int k = 0; k < NO; k++) begin
         step("R4 demux one", 1'b0, 1'b0, AW'(k), 1'b1, 1'b0);
         step("R4 demux zero", 1'b0, 1'b0, AW'(k), 1'b0, 1'b0);
      end
      step("R4 demux", 1'b0, 1'b0, 3'd4, 1'b1, 1'b0);
      step("R6 demux to hold", 1'b1, 1'b1, 3'd1, 1'b1, 1'b0);

      // R8: system reset against a write of 1
      step("R1 write", 1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
      srst = 1'b1;
      step("R8 srst over write", 1'b0, 1'b1, 3'd5, 1'b1, 1'b0);
      srst = 1'b0;
      step("R8 after srst", 1'b1, 1'b1, 3'd5, 1'b1, 1'b0);

      // random mix of modes, addresses, data and glitches
      void'($urandom(32'd4242));
      for (int i = 0; i < 800; i++) begin
         int unsigned m;
         logic en_n, cl_n;
         m = $urandom_range(0, 9);
         if (m < 5)      begin en_n = 1'b0; cl_n = 1'b1; end
         else if (m < 7) begin en_n = 1'b1; cl_n = 1'b1; end
         else if (m < 9) begin en_n = 1'b0; cl_n = 1'b0; end
         else            begin en_n = 1'b1; cl_n = 1'b0; end
         srst = ($urandom_range(0, 49) == 0);
         step("R1-mode random", en_n, cl_n, AW'($urandom_range(0, NO-1)),
              1'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0));
      end
      srst = 1'b0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule